// File: doc/BRIEF.md
# Masked-Write Clock Gate Register Bank

This block is a small bank of memory-mapped control registers that tells downstream modules whether their clock runs and whether they are out of reset. Each control register holds 16 live bits. Every bus write carries its own 16-bit write mask in the upper half of the data word, so software can flip the bit for one module without reading the register first and without disturbing the modules that share the register.

For each clock-enable register there is a read-only status register, placed at the enable register's address plus 0x180. Its bits show, in the same bit positions, which gated clocks are really running. A status bit follows its enable bit after a fixed number of cycles. This delay models the handshake with the clock gating cell. After turning a clock on, software polls the status bit until it reads 1. The reset-control registers use the same masked write. A 0 in a data bit holds that module in reset and a 1 lets it run. The gating cells themselves are not part of the block.

Top module: `clk_gate_bank`

## Requirements
- R1: A write to a control register changes data bit k (k in 0..15) only when bit 16+k of the same write word is 1. Bits whose mask bit is 0 keep their old value.
- R2: In a clock-enable register (register i at address 0x000 + 4*i), writing 1 through the mask turns on output bit `clk_en_o[16*i+k]` and writing 0 turns it off. The output changes at the clock edge that accepts the write.
- R3: The status register at the enable register's address + 0x180 reports bit k = 1 exactly MON_LAT (default 3) cycles after the enable output bit k becomes 1. A bus read made at the MON_LAT+1-th edge after the write edge is the first read that shows the new value.
- R4: When an enable bit is cleared, its status bit returns to 0 with the same MON_LAT-cycle delay.
- R5: Reset-control register j (address 0x080 + 4*j) uses the same masked write. Data bit 0 drives `mod_rst_n_o[16*j+k]` low, which holds the module in reset. Data bit 1 drives it high, which releases the module.
- R6: Reading a clock-enable or reset-control register returns its 16 data bits in bits 15:0. Bits 31:16 always read as 0.
- R7: A write to an unmapped address has no effect on any output. This includes addresses that are not word aligned. A read from an unmapped address returns 0.
- R8: While reset is asserted, every clock-enable bit, every reset-control bit and every status bit is 0.
- R9: The status registers are read-only. A write to a status address changes no register and no output.
- R10: Read data is registered. It appears after the edge that accepts `bus_rd_en` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, one word per cycle |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write word: bits 31:16 are the mask, bits 15:0 the data |
| bus_rdata | output | 32 | Registered read data |
| clk_en_o | output | 16*NUM_CLK_REGS | Clock-enable bit for each downstream module |
| mod_rst_n_o | output | 16*NUM_RST_REGS | Active-low reset for each downstream module |

## Verification
The hardest case to reach is the exact cycle in which a status bit flips. From the ports it can only be seen through registered bus reads, and only after the enable has already settled. The bench does the write and then, with no gap, issues back-to-back status reads starting at the very next edge. It expects exactly MON_LAT reads that still show the old status, and then the new value. The same sequence is repeated for turning a clock off. The bench also writes through masks that overlap set and cleared bits, writes to unmapped, misaligned and status addresses, and then confirms that every output is left as it was.

// File: rtl/cgb_pkg.sv
package cgb_pkg;
   localparam int HALF_W = 16;
   localparam int BUS_W  = 2 * HALF_W;

   typedef logic [HALF_W-1:0] half_t;
   typedef logic [BUS_W-1:0]  word_t;

   // merge a write word into a stored half: mask in the upper half selects bits
   function automatic half_t masked_merge(half_t cur, word_t w);
      half_t m;
      m = w[BUS_W-1:HALF_W];
      return (cur & ~m) | (w[HALF_W-1:0] & m);
   endfunction
endpackage

// File: rtl/cgb_mask_reg.sv
module cgb_mask_reg
   import cgb_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  we,
   input  word_t wdata,
   output half_t q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= masked_merge(q, wdata);
   end
endmodule

// File: rtl/cgb_mon_pipe.sv
module cgb_mon_pipe #(
   parameter int WIDTH = 16,
   parameter int LAT   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [LAT-1:0][WIDTH-1:0] stage;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage <= '0;
      else begin
         stage[0] <= d;
         for (int k = 1; k < LAT; k++) stage[k] <= stage[k-1];
      end
   end

   assign q = stage[LAT-1];
endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank
   import cgb_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int NUM_CLK_REGS = 2,
   parameter int NUM_RST_REGS = 2,
   parameter int CLK_BASE     = 'h000,
   parameter int RST_BASE     = 'h080,
   parameter int MON_OFFSET   = 'h180,
   parameter int MON_LAT      = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           bus_wr_en,
   input  logic                           bus_rd_en,
   input  logic [ADDR_W-1:0]              bus_addr,
   input  logic [31:0]                    bus_wdata,
   output logic [31:0]                    bus_rdata,
   output logic [16*NUM_CLK_REGS-1:0]     clk_en_o,
   output logic [16*NUM_RST_REGS-1:0]     mod_rst_n_o
);
   localparam int CLK_END = CLK_BASE + 4 * NUM_CLK_REGS;
   localparam int RST_END = RST_BASE + 4 * NUM_RST_REGS;
   localparam int MON_BASE = CLK_BASE + MON_OFFSET;
   localparam int MON_END  = MON_BASE + 4 * NUM_CLK_REGS;

   // elaboration-time parameter checks
   if (MON_LAT < 1) begin : g_bad_lat
      $error("clk_gate_bank: MON_LAT must be at least 1");
   end
   if (NUM_CLK_REGS < 1 || NUM_RST_REGS < 1) begin : g_bad_cnt
      $error("clk_gate_bank: register counts must be at least 1");
   end
   if (!(CLK_END <= RST_BASE || RST_END <= CLK_BASE)) begin : g_bad_ovl
      $error("clk_gate_bank: clock and reset windows overlap");
   end
   if (!(RST_END <= MON_BASE || MON_END <= RST_BASE) || MON_OFFSET < 4 * NUM_CLK_REGS) begin : g_bad_mon
      $error("clk_gate_bank: status window collides with a control window");
   end
   if (MON_END > (1 << ADDR_W) || RST_END > (1 << ADDR_W)) begin : g_bad_aw
      $error("clk_gate_bank: ADDR_W too narrow for the map");
   end

   logic [NUM_CLK_REGS-1:0][HALF_W-1:0] clk_q;
   logic [NUM_CLK_REGS-1:0][HALF_W-1:0] mon_flat;
   logic [NUM_RST_REGS-1:0][HALF_W-1:0] rst_q;
   word_t rd_mux;

   for (genvar i = 0; i < NUM_CLK_REGS; i++) begin : g_clk
      logic hit;
      assign hit = bus_wr_en && (bus_addr == ADDR_W'(CLK_BASE + 4 * i));
      cgb_mask_reg u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (hit),
         .wdata (bus_wdata),
         .q     (clk_q[i])
      );
      cgb_mon_pipe #(.WIDTH(HALF_W), .LAT(MON_LAT)) u_mon (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (clk_q[i]),
         .q     (mon_flat[i])
      );
   end

   for (genvar j = 0; j < NUM_RST_REGS; j++) begin : g_rst
      logic hit;
      assign hit = bus_wr_en && (bus_addr == ADDR_W'(RST_BASE + 4 * j));
      cgb_mask_reg u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (hit),
         .wdata (bus_wdata),
         .q     (rst_q[j])
      );
   end

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NUM_CLK_REGS; i++) begin
         if (bus_addr == ADDR_W'(CLK_BASE + 4 * i)) rd_mux = rd_mux | {{HALF_W{1'b0}}, clk_q[i]};
         if (bus_addr == ADDR_W'(MON_BASE + 4 * i)) rd_mux = rd_mux | {{HALF_W{1'b0}}, mon_flat[i]};
      end
      for (int j = 0; j < NUM_RST_REGS; j++) begin
         if (bus_addr == ADDR_W'(RST_BASE + 4 * j)) rd_mux = rd_mux | {{HALF_W{1'b0}}, rst_q[j]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bus_rdata <= '0;
      else if (bus_rd_en) bus_rdata <= rd_mux;
   end

   assign clk_en_o    = clk_q;
   assign mod_rst_n_o = rst_q;
endmodule

// File: rtl/cgb_checker.sv
module cgb_checker #(
   parameter int ADDR_W       = 12,
   parameter int NUM_CLK_REGS = 2,
   parameter int NUM_RST_REGS = 2,
   parameter int CLK_BASE     = 'h000,
   parameter int RST_BASE     = 'h080,
   parameter int MON_LAT      = 3
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       bus_wr_en,
   input logic [ADDR_W-1:0]          bus_addr,
   input logic [31:0]                bus_wdata,
   input logic [31:0]                bus_rdata,
   input logic [16*NUM_CLK_REGS-1:0] clk_en_o,
   input logic [16*NUM_RST_REGS-1:0] mod_rst_n_o,
   input logic [16*NUM_CLK_REGS-1:0] mon_flat
);
   logic [1:0] cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cyc <= '0;
      else if (cyc != 3) cyc <= cyc + 2'd1;
   end

   for (genvar i = 0; i < NUM_CLK_REGS; i++) begin : g_c
      assert_masked_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr_en && bus_addr == ADDR_W'(CLK_BASE + 4 * i)) |=>
         (((clk_en_o[16*i +: 16] ^ $past(clk_en_o[16*i +: 16])) & ~$past(bus_wdata[31:16])) == 16'h0));
      assert_masked_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr_en && bus_addr == ADDR_W'(CLK_BASE + 4 * i)) |=>
         ((clk_en_o[16*i +: 16] & $past(bus_wdata[31:16])) == ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16]))));
   end

   for (genvar j = 0; j < NUM_RST_REGS; j++) begin : g_r
      assert_rst_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr_en && bus_addr == ADDR_W'(RST_BASE + 4 * j)) |=>
         ((mod_rst_n_o[16*j +: 16] & $past(bus_wdata[31:16])) == ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16]))));
   end

   assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr_en |=> ($stable(clk_en_o) && $stable(mod_rst_n_o)));

   if (MON_LAT == 3) begin : g_lat3
      assert_mon_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (cyc == 2'd3) |-> (mon_flat == $past(clk_en_o, 3)));
   end

   assert_rdata_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[31:16] == 16'h0);

   always_comb begin
      if (!rst_n) begin
         assert_reset_zero_R8: assert (clk_en_o == '0 && mod_rst_n_o == '0 && mon_flat == '0);
      end
   end
endmodule

bind clk_gate_bank cgb_checker #(
   .ADDR_W(ADDR_W), .NUM_CLK_REGS(NUM_CLK_REGS), .NUM_RST_REGS(NUM_RST_REGS),
   .CLK_BASE(CLK_BASE), .RST_BASE(RST_BASE), .MON_LAT(MON_LAT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_en_o(clk_en_o),
   .mod_rst_n_o(mod_rst_n_o), .mon_flat(mon_flat)
);

// File: tb/clk_gate_bank_test.sv
`timescale 1ns/1ps
module clk_gate_bank_test;
   localparam int AW = 12;
   localparam int LAT = 3;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        bus_wr_en = 0;
   logic        bus_rd_en = 0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] clk_en_o;
   logic [31:0] mod_rst_n_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   clk_gate_bank uut (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .clk_en_o(clk_en_o), .mod_rst_n_o(mod_rst_n_o)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr_en = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr_en = 0;
   endtask

   task automatic bus_read(logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd_en = 1; bus_addr = a;
      @(posedge clk); #1;
      bus_rd_en = 0;
      d = bus_rdata;
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R8 clk_en after reset", clk_en_o, 32'h0);
      check("R8 rst_n out after reset", mod_rst_n_o, 32'h0);
      bus_read(12'h000, d); check("R8 enable reg after reset", d, 32'h0);
      bus_read(12'h180, d); check("R8 status after reset", d, 32'h0);
   endtask

   task automatic t_masked_clk();
      logic [31:0] d;
      bus_write(12'h000, 32'h00FF_FFFF);
      check("R2 set low byte", clk_en_o, 32'h0000_00FF);
      bus_write(12'h000, 32'h0F0F_0000);
      check("R1 partial clear", clk_en_o, 32'h0000_00F0);
      bus_write(12'h000, 32'h0000_FFFF);
      check("R1 zero mask no change", clk_en_o, 32'h0000_00F0);
      bus_write(12'h004, 32'hFFFF_A5A5);
      check("R2 second register", clk_en_o, 32'hA5A5_00F0);
      bus_read(12'h000, d); check("R6 readback reg0", d, 32'h0000_00F0);
      bus_read(12'h004, d); check("R6 readback reg1", d, 32'h0000_A5A5);
   endtask

   task automatic t_monitor();
      logic [31:0] d;
      idle(LAT + 2);
      bus_write(12'h000, 32'h0001_0001);
      check("R2 enable bit0", clk_en_o, 32'hA5A5_00F1);
      for (int n = 0; n < LAT; n++) begin
         bus_read(12'h180, d); check("R3 status still old", d, 32'h0000_00F0);
      end
      bus_read(12'h180, d); check("R3 status shows enable", d, 32'h0000_00F1);
      bus_read(12'h184, d); check("R3 status reg1", d, 32'h0000_A5A5);
      idle(LAT + 2);
      bus_write(12'h000, 32'h0001_0000);
      for (int n = 0; n < LAT; n++) begin
         bus_read(12'h180, d); check("R4 status still on", d, 32'h0000_00F1);
      end
      bus_read(12'h180, d); check("R4 status shows disable", d, 32'h0000_00F0);
   endtask

   task automatic t_mon_readonly();
      logic [31:0] d;
      bus_write(12'h180, 32'hFFFF_0000);
      bus_write(12'h184, 32'hFFFF_FFFF);
      check("R9 outputs untouched", clk_en_o, 32'hA5A5_00F0);
      idle(LAT + 2);
      bus_read(12'h180, d); check("R9 status unchanged", d, 32'h0000_00F0);
   endtask

   task automatic t_reset_ctl();
      logic [31:0] d;
      bus_write(12'h080, 32'h8001_8001);
      check("R5 release two modules", mod_rst_n_o, 32'h0000_8001);
      bus_write(12'h080, 32'h0001_0000);
      check("R5 re-hold bit0", mod_rst_n_o, 32'h0000_8000);
      bus_write(12'h084, 32'h00F0_FFFF);
      check("R5 reg1 masked", mod_rst_n_o, 32'h00F0_8000);
      bus_read(12'h080, d); check("R6 reset reg readback", d, 32'h0000_8000);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      bus_write(12'h040, 32'hFFFF_FFFF);
      bus_write(12'h002, 32'hFFFF_0000);
      bus_write(12'h082, 32'hFFFF_0000);
      check("R7 clk_en unchanged", clk_en_o, 32'hA5A5_00F0);
      check("R7 rst out unchanged", mod_rst_n_o, 32'h00F0_8000);
      bus_read(12'h040, d); check("R7 unmapped read", d, 32'h0);
      bus_read(12'h0C0, d); check("R7 unmapped read 2", d, 32'h0);
   endtask

   task automatic t_read_hold();
      logic [31:0] d;
      bus_read(12'h004, d); check("R10 read data", d, 32'h0000_A5A5);
      @(negedge clk); bus_addr = 12'h000;
      idle(2);
      check("R10 data held without read", bus_rdata, 32'h0000_A5A5);
   endtask

   initial begin
      #(20 * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1;
      check("R8 outputs in reset", clk_en_o | mod_rst_n_o, 32'h0);
      repeat (4) @(posedge clk);
      #1 rst_n = 1;
      t_reset();
      t_masked_clk();
      t_monitor();
      t_mon_readonly();
      t_reset_ctl();
      t_unmapped();
      t_read_hold();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule